// File: doc/BRIEF.md
# Block-Granular Stream-to-Memory DMA Sequencer

This block moves data between a byte stream and a 16-bit cartridge memory port. The amount moved is always a whole number of 512-byte blocks. Software first programs a block count and a start address. It then writes a command code, which picks one of four routes and starts the transfer. The four routes are SD side into memory, memory out to the SD side, USB side into memory, and memory out to the USB side. Each stream side has a valid/ready byte interface in each direction. The memory side uses single-cycle write and read strobes. Read data returns on the cycle after the read strobe.

Two status outputs report progress. The busy output is high while a transfer is running. The timeout output is sticky and is raised when a transfer is abandoned because its stream stopped moving. When that happens, fewer bytes than programmed were moved. The next accepted command clears the timeout output. The SD card protocol, the USB FIFO device and the memory controller are outside this block.

Top module: `blkdma_seq`

## Requirements
- R1: After reset, stat_busy and stat_timeout are 0, no stream ready or valid is asserted, and neither memory strobe is active.
- R2: A write with cfg_sel=2 and a data value of 1, 2, 3 or 4 starts a transfer, and stat_busy is 1 from the next cycle. The codes are: 1 = SD stream into memory, 2 = memory to SD stream, 3 = USB stream into memory, 4 = memory to USB stream.
- R3: A write with cfg_sel=2 and any other data value is ignored. stat_busy stays 0 and stat_timeout keeps its value.
- R4: The length register (cfg_sel=0, low 16 bits) holds L. The transfer moves (L+1)*512 bytes, and stat_busy falls on the clock edge that takes the final byte.
- R5: The base register (cfg_sel=1, low 16 bits) holds A. The first memory word is at byte address A*2048, and each later word is at the previous address plus 2.
- R6: On the inbound routes, bytes are paired into 16-bit words. The earlier byte goes in bits 15:8 and the later byte in bits 7:0. Each complete word is written with one mem_wr strobe.
- R7: On the outbound routes, each word is fetched with one mem_rd strobe. Bits 15:8 are sent before bits 7:0. mem_wr and mem_rd are never active together.
- R8: Only the stream selected by the current command sees rx_ready or tx_valid. All other stream handshake outputs stay 0.
- R9: If the block waits TIMEOUT_CYCLES (default 4096) consecutive cycles with no byte accepted, it drops stat_busy on that edge and sets stat_timeout. Words completed earlier stay written, and a pending odd byte is discarded.
- R10: stat_timeout stays 1 until the next accepted command, which clears it.
- R11: While stat_busy is 1, command writes are ignored. Length and base writes made during a transfer do not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 length, 1 base, 2 command |
| cfg_wdata | input | 16 | Configuration write data |
| stat_busy | output | 1 | Transfer in progress |
| stat_timeout | output | 1 | Sticky: last transfer was abandoned |
| sd_rx_valid | input | 1 | SD inbound byte valid |
| sd_rx_data | input | 8 | SD inbound byte |
| sd_rx_ready | output | 1 | Block accepts SD inbound byte |
| sd_tx_valid | output | 1 | SD outbound byte valid |
| sd_tx_data | output | 8 | SD outbound byte |
| sd_tx_ready | input | 1 | SD side accepts outbound byte |
| usb_rx_valid | input | 1 | USB inbound byte valid |
| usb_rx_data | input | 8 | USB inbound byte |
| usb_rx_ready | output | 1 | Block accepts USB inbound byte |
| usb_tx_valid | output | 1 | USB outbound byte valid |
| usb_tx_data | output | 8 | USB outbound byte |
| usb_tx_ready | input | 1 | USB side accepts outbound byte |
| mem_wr | output | 1 | Memory word write strobe |
| mem_rd | output | 1 | Memory word read strobe |
| mem_addr | output | 27 | Memory byte address |
| mem_wdata | output | 16 | Memory write word |
| mem_rdata | input | 16 | Memory read word, valid the cycle after mem_rd |

## Verification
The bench targets four corner cases.

The first is the exact edge on which busy falls. It is checked both after the final byte of a multi-block inbound transfer and after the 4096th idle cycle of a starved one. A length counted one block short, or a timer that is off by one, would move this edge by a cycle.

The second is a starved transfer that stops on an odd byte. A design that flushed the half-filled word, or kept writing after the abort, would show an extra memory write.

The third is command writes made mid-transfer, together with invalid codes written while idle. A design that restarted on those writes, or cleared the sticky flag on a rejected code, would corrupt data or lose the timeout indication.

The fourth is byte order in both directions. A design that swapped lanes, or routed handshakes to the unselected stream, would fail the per-word compares and the cross-stream monitor.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

   typedef enum logic [2:0] {
      DIR_NONE    = 3'd0,
      DIR_SD_IN   = 3'd1,
      DIR_SD_OUT  = 3'd2,
      DIR_USB_IN  = 3'd3,
      DIR_USB_OUT = 3'd4
   } dir_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_IN,
      ST_RD_REQ,
      ST_RD_WAIT,
      ST_SEND_HI,
      ST_SEND_LO
   } eng_st_e;

   localparam logic [1:0] SEL_LEN  = 2'd0;
   localparam logic [1:0] SEL_BASE = 2'd1;
   localparam logic [1:0] SEL_CMD  = 2'd2;

   function automatic logic dir_is_in(input dir_e d);
      return (d == DIR_SD_IN) || (d == DIR_USB_IN);
   endfunction

endpackage

// File: rtl/dmaseq_cfg.sv
module dmaseq_cfg
   import dmaseq_pkg::*;
#(
   parameter int CFG_W  = 16,
   parameter int LEN_W  = 16,
   parameter int BASE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              busy,
   output logic [LEN_W-1:0]  len_q,
   output logic [BASE_W-1:0] base_q,
   output logic              start,
   output dir_e              start_dir
);

   logic code_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q  <= '0;
         base_q <= '0;
      end else if (cfg_we) begin
         if (cfg_sel == SEL_LEN)  len_q  <= cfg_wdata[LEN_W-1:0];
         if (cfg_sel == SEL_BASE) base_q <= cfg_wdata[BASE_W-1:0];
      end
   end

   always_comb begin
      code_ok   = (cfg_wdata >= CFG_W'(1)) && (cfg_wdata <= CFG_W'(4));
      start     = cfg_we && (cfg_sel == SEL_CMD) && code_ok && !busy;
      start_dir = dir_e'(cfg_wdata[2:0]);
   end

endmodule

// File: rtl/dmaseq_port_mux.sv
module dmaseq_port_mux
   import dmaseq_pkg::*;
(
   input  dir_e        dir,
   input  logic        in_ready,
   input  logic        out_valid,
   input  logic [7:0]  out_data,
   output logic        in_valid,
   output logic [7:0]  in_data,
   output logic        out_ready,
   input  logic        sd_rx_valid,
   input  logic [7:0]  sd_rx_data,
   output logic        sd_rx_ready,
   output logic        sd_tx_valid,
   output logic [7:0]  sd_tx_data,
   input  logic        sd_tx_ready,
   input  logic        usb_rx_valid,
   input  logic [7:0]  usb_rx_data,
   output logic        usb_rx_ready,
   output logic        usb_tx_valid,
   output logic [7:0]  usb_tx_data,
   input  logic        usb_tx_ready
);

   localparam int NPORT = 2;

   logic [NPORT-1:0] sel_in, sel_out;
   logic [NPORT-1:0] p_rx_valid, p_rx_ready, p_tx_valid, p_tx_ready;

   assign p_rx_valid = {usb_rx_valid, sd_rx_valid};
   assign p_tx_ready = {usb_tx_ready, sd_tx_ready};

   for (genvar g = 0; g < NPORT; g++) begin : g_port
      localparam dir_e IN_C  = (g == 0) ? DIR_SD_IN  : DIR_USB_IN;
      localparam dir_e OUT_C = (g == 0) ? DIR_SD_OUT : DIR_USB_OUT;
      assign sel_in[g]     = (dir == IN_C);
      assign sel_out[g]    = (dir == OUT_C);
      assign p_rx_ready[g] = in_ready  & sel_in[g];
      assign p_tx_valid[g] = out_valid & sel_out[g];
   end

   assign in_valid     = |(p_rx_valid & sel_in);
   assign in_data      = sel_in[1] ? usb_rx_data : sd_rx_data;
   assign out_ready    = |(p_tx_ready & sel_out);
   assign sd_rx_ready  = p_rx_ready[0];
   assign usb_rx_ready = p_rx_ready[1];
   assign sd_tx_valid  = p_tx_valid[0];
   assign usb_tx_valid = p_tx_valid[1];
   assign sd_tx_data   = out_data;
   assign usb_tx_data  = out_data;

endmodule

// File: rtl/dmaseq_idle_timer.sv
module dmaseq_idle_timer #(
   parameter int TIMEOUT_CYCLES = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic waiting,
   input  logic hs,
   output logic expire
);

   localparam int TMR_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
   localparam logic [TMR_W-1:0] LAST = TMR_W'(TIMEOUT_CYCLES - 1);

   logic [TMR_W-1:0] cnt;

   assign expire = waiting && !hs && !start && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else if (start || !waiting || hs || expire) cnt <= '0;
      else cnt <= cnt + TMR_W'(1);
   end

endmodule

// File: rtl/dmaseq_engine.sv
module dmaseq_engine
   import dmaseq_pkg::*;
#(
   parameter int LEN_W      = 16,
   parameter int BASE_W     = 16,
   parameter int BLK_SH     = 9,
   parameter int UNIT_SH    = 11,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  dir_e                       start_dir,
   input  logic [LEN_W-1:0]           len,
   input  logic [BASE_W-1:0]          base,
   input  logic                       expire,
   input  logic                       in_valid,
   input  logic [7:0]                 in_data,
   output logic                       in_ready,
   input  logic                       out_ready,
   output logic                       out_valid,
   output logic [7:0]                 out_data,
   output logic                       mem_wr,
   output logic                       mem_rd,
   output logic [BASE_W+UNIT_SH-1:0]  mem_addr,
   output logic [15:0]                mem_wdata,
   input  logic [15:0]                mem_rdata,
   output logic                       busy,
   output logic                       timeout,
   output logic                       waiting,
   output logic                       hs,
   output dir_e                       dir
);

   localparam int ADDR_W = BASE_W + UNIT_SH;
   localparam int LEFT_W = LEN_W + BLK_SH;

   eng_st_e           state;
   logic [LEFT_W-1:0] left;
   logic [ADDR_W-1:0] cur_addr;
   logic [7:0]        hold;
   logic              phase;
   logic [15:0]       word_q;
   logic              wr_q;
   logic [15:0]       wdata_q;
   logic              tmo_q;
   dir_e              dir_q;
   logic [15:0]       packed_word;
   logic [7:0]        first_byte, second_byte;

   if (BIG_ENDIAN) begin : g_be
      assign packed_word = {hold, in_data};
      assign first_byte  = word_q[15:8];
      assign second_byte = word_q[7:0];
   end else begin : g_le
      assign packed_word = {in_data, hold};
      assign first_byte  = word_q[7:0];
      assign second_byte = word_q[15:8];
   end

   assign busy      = (state != ST_IDLE);
   assign in_ready  = (state == ST_IN);
   assign out_valid = (state == ST_SEND_HI) || (state == ST_SEND_LO);
   assign out_data  = (state == ST_SEND_HI) ? first_byte : second_byte;
   assign mem_rd    = (state == ST_RD_REQ);
   assign mem_wr    = wr_q;
   assign mem_wdata = wdata_q;
   assign mem_addr  = cur_addr;
   assign timeout   = tmo_q;
   assign dir       = dir_q;
   assign waiting   = in_ready || out_valid;
   assign hs        = in_ready ? in_valid : (out_valid && out_ready);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         left     <= '0;
         cur_addr <= '0;
         hold     <= '0;
         phase    <= 1'b0;
         word_q   <= '0;
         wr_q     <= 1'b0;
         wdata_q  <= '0;
         tmo_q    <= 1'b0;
         dir_q    <= DIR_NONE;
      end else begin
         wr_q <= 1'b0;
         if (wr_q || state == ST_RD_REQ) cur_addr <= cur_addr + ADDR_W'(2);
         if (start) begin
            left     <= {len, {BLK_SH{1'b1}}};
            cur_addr <= {base, {UNIT_SH{1'b0}}};
            phase    <= 1'b0;
            tmo_q    <= 1'b0;
            dir_q    <= start_dir;
            state    <= dir_is_in(start_dir) ? ST_IN : ST_RD_REQ;
         end else if (expire) begin
            state <= ST_IDLE;
            tmo_q <= 1'b1;
         end else begin
            unique case (state)
               ST_IN: if (in_valid) begin
                  left <= left - LEFT_W'(1);
                  if (!phase) begin
                     hold  <= in_data;
                     phase <= 1'b1;
                  end else begin
                     wr_q    <= 1'b1;
                     wdata_q <= packed_word;
                     phase   <= 1'b0;
                  end
                  if (left == '0) state <= ST_IDLE;
               end
               ST_RD_REQ:  state <= ST_RD_WAIT;
               ST_RD_WAIT: begin
                  word_q <= mem_rdata;
                  state  <= ST_SEND_HI;
               end
               ST_SEND_HI: if (out_ready) begin
                  left  <= left - LEFT_W'(1);
                  state <= ST_SEND_LO;
               end
               ST_SEND_LO: if (out_ready) begin
                  left  <= left - LEFT_W'(1);
                  state <= (left == '0) ? ST_IDLE : ST_RD_REQ;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/blkdma_seq.sv
module blkdma_seq
   import dmaseq_pkg::*;
#(
   parameter int CFG_W          = 16,
   parameter int LEN_W          = 16,
   parameter int BASE_W         = 16,
   parameter int BLOCK_BYTES    = 512,
   parameter int UNIT_BYTES     = 2048,
   parameter int TIMEOUT_CYCLES = 4096,
   parameter bit BIG_ENDIAN     = 1'b1
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    cfg_we,
   input  logic [1:0]                              cfg_sel,
   input  logic [CFG_W-1:0]                        cfg_wdata,
   output logic                                    stat_busy,
   output logic                                    stat_timeout,
   input  logic                                    sd_rx_valid,
   input  logic [7:0]                              sd_rx_data,
   output logic                                    sd_rx_ready,
   output logic                                    sd_tx_valid,
   output logic [7:0]                              sd_tx_data,
   input  logic                                    sd_tx_ready,
   input  logic                                    usb_rx_valid,
   input  logic [7:0]                              usb_rx_data,
   output logic                                    usb_rx_ready,
   output logic                                    usb_tx_valid,
   output logic [7:0]                              usb_tx_data,
   input  logic                                    usb_tx_ready,
   output logic                                    mem_wr,
   output logic                                    mem_rd,
   output logic [BASE_W+$clog2(UNIT_BYTES)-1:0]    mem_addr,
   output logic [15:0]                             mem_wdata,
   input  logic [15:0]                             mem_rdata
);

   localparam int BLK_SH  = $clog2(BLOCK_BYTES);
   localparam int UNIT_SH = $clog2(UNIT_BYTES);

   if (BLOCK_BYTES < 2 || (BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_bad_blk
      $error("BLOCK_BYTES must be a power of two of at least 2");
   end
   if (UNIT_BYTES < 2 || (UNIT_BYTES & (UNIT_BYTES - 1)) != 0) begin : g_bad_unit
      $error("UNIT_BYTES must be a power of two of at least 2");
   end
   if (TIMEOUT_CYCLES < 2) begin : g_bad_tmo
      $error("TIMEOUT_CYCLES must be at least 2");
   end
   if (CFG_W < LEN_W || CFG_W < BASE_W || CFG_W < 3) begin : g_bad_cfg
      $error("CFG_W too narrow for the programmed fields");
   end

   logic              cmd_start;
   dir_e              start_dir, cur_dir;
   logic [LEN_W-1:0]  len_q;
   logic [BASE_W-1:0] base_q;
   logic              expire, waiting, hs;
   logic              in_valid, in_ready, out_valid, out_ready;
   logic [7:0]        in_data, out_data;

   dmaseq_cfg #(.CFG_W(CFG_W), .LEN_W(LEN_W), .BASE_W(BASE_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .busy      (stat_busy),
      .len_q     (len_q),
      .base_q    (base_q),
      .start     (cmd_start),
      .start_dir (start_dir)
   );

   dmaseq_idle_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (cmd_start),
      .waiting (waiting),
      .hs      (hs),
      .expire  (expire)
   );

   dmaseq_engine #(
      .LEN_W(LEN_W), .BASE_W(BASE_W), .BLK_SH(BLK_SH),
      .UNIT_SH(UNIT_SH), .BIG_ENDIAN(BIG_ENDIAN)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cmd_start),
      .start_dir (start_dir),
      .len       (len_q),
      .base      (base_q),
      .expire    (expire),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .mem_wr    (mem_wr),
      .mem_rd    (mem_rd),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .busy      (stat_busy),
      .timeout   (stat_timeout),
      .waiting   (waiting),
      .hs        (hs),
      .dir       (cur_dir)
   );

   dmaseq_port_mux u_mux (
      .dir          (cur_dir),
      .in_ready     (in_ready),
      .out_valid    (out_valid),
      .out_data     (out_data),
      .in_valid     (in_valid),
      .in_data      (in_data),
      .out_ready    (out_ready),
      .sd_rx_valid  (sd_rx_valid),
      .sd_rx_data   (sd_rx_data),
      .sd_rx_ready  (sd_rx_ready),
      .sd_tx_valid  (sd_tx_valid),
      .sd_tx_data   (sd_tx_data),
      .sd_tx_ready  (sd_tx_ready),
      .usb_rx_valid (usb_rx_valid),
      .usb_rx_data  (usb_rx_data),
      .usb_rx_ready (usb_rx_ready),
      .usb_tx_valid (usb_tx_valid),
      .usb_tx_data  (usb_tx_data),
      .usb_tx_ready (usb_tx_ready)
   );

endmodule

// File: rtl/dmaseq_checker.sv
module dmaseq_checker #(
   parameter int CFG_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [1:0]       cfg_sel,
   input logic [CFG_W-1:0] cfg_wdata,
   input logic             stat_busy,
   input logic             stat_timeout,
   input logic             sd_rx_ready,
   input logic             sd_tx_valid,
   input logic             usb_rx_ready,
   input logic             usb_tx_valid,
   input logic             mem_wr,
   input logic             mem_rd,
   input logic             cmd_start
);

   logic cmd_wr, code_good;
   assign cmd_wr    = cfg_we && (cfg_sel == 2'd2);
   assign code_good = (cfg_wdata >= CFG_W'(1)) && (cfg_wdata <= CFG_W'(4));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_busy |-> !(sd_rx_ready || usb_rx_ready || sd_tx_valid || usb_tx_valid || mem_rd));

   assert_start_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_busy) |-> $past(cmd_wr && code_good));

   assert_bad_code_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_busy && cmd_wr && !code_good) |=> !stat_busy);

   assert_mem_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr && mem_rd));

   assert_one_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sd_rx_ready, sd_tx_valid, usb_rx_ready, usb_tx_valid}));

   assert_timeout_ends_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_timeout) |-> $fell(stat_busy));

   assert_timeout_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_busy) |-> !stat_timeout);

   assert_timeout_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_timeout && !cmd_start) |=> stat_timeout);

   assert_no_restart_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stat_busy |-> !cmd_start);

endmodule

bind blkdma_seq dmaseq_checker #(.CFG_W(CFG_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .cfg_sel      (cfg_sel),
   .cfg_wdata    (cfg_wdata),
   .stat_busy    (stat_busy),
   .stat_timeout (stat_timeout),
   .sd_rx_ready  (sd_rx_ready),
   .sd_tx_valid  (sd_tx_valid),
   .usb_rx_ready (usb_rx_ready),
   .usb_tx_valid (usb_tx_valid),
   .mem_wr       (mem_wr),
   .mem_rd       (mem_rd),
   .cmd_start    (cmd_start)
);

// File: tb/blkdma_seq_bench.sv
`timescale 1ns/1ps
module blkdma_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [1:0]  cfg_sel;
   logic [15:0] cfg_wdata;
   logic        stat_busy, stat_timeout;
   logic        sd_rx_valid, sd_rx_ready, sd_tx_valid, sd_tx_ready;
   logic [7:0]  sd_rx_data, sd_tx_data;
   logic        usb_rx_valid, usb_rx_ready, usb_tx_valid, usb_tx_ready;
   logic [7:0]  usb_rx_data, usb_tx_data;
   logic        mem_wr, mem_rd;
   logic [26:0] mem_addr;
   logic [15:0] mem_wdata, mem_rdata;

   int n_chk = 0;
   int n_fail = 0;
   int wr_cnt = 0;
   int viol = 0;
   int exp_code = 0;
   logic [15:0] wmem [0:4095];
   logic [7:0]  rx_bytes [0:1023];

   always #2.5 clk = ~clk;

   blkdma_seq u_blkdma_seq (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .stat_busy(stat_busy), .stat_timeout(stat_timeout),
      .sd_rx_valid(sd_rx_valid), .sd_rx_data(sd_rx_data), .sd_rx_ready(sd_rx_ready),
      .sd_tx_valid(sd_tx_valid), .sd_tx_data(sd_tx_data), .sd_tx_ready(sd_tx_ready),
      .usb_rx_valid(usb_rx_valid), .usb_rx_data(usb_rx_data), .usb_rx_ready(usb_rx_ready),
      .usb_tx_valid(usb_tx_valid), .usb_tx_data(usb_tx_data), .usb_tx_ready(usb_tx_ready),
      .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   function automatic logic [15:0] rdpat(input logic [11:0] i);
      return {i[7:0] ^ 8'h5A, i[11:4] + 8'h33};
   endfunction

   function automatic logic [7:0] bytev(input int seed, input int i);
      return 8'(i * seed + (i >> 8) + seed * 3);
   endfunction

   // memory model: write capture and one-cycle read latency
   always @(posedge clk) begin
      if (mem_wr) begin
         wmem[mem_addr[12:1]] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      if (mem_rd) mem_rdata <= rdpat(mem_addr[12:1]);
   end

   // cross-stream monitor (R8)
   always @(negedge clk) begin
      if (sd_rx_ready  && exp_code != 1) viol <= viol + 1;
      if (sd_tx_valid  && exp_code != 2) viol <= viol + 1;
      if (usb_rx_ready && exp_code != 3) viol <= viol + 1;
      if (usb_tx_valid && exp_code != 4) viol <= viol + 1;
   end

   task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [1:0] sel, input logic [15:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic push(input int port, input int n, input int seed, input bit meddle);
      logic got;
      for (int i = 0; i < n; i++) begin
         if (i % 5 == 4) begin
            sd_rx_valid = 1'b0; usb_rx_valid = 1'b0;
            @(negedge clk);
         end
         if (meddle) begin
            if (i == 100) begin cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 16'd4; end
            if (i == 101) begin cfg_sel = 2'd0; cfg_wdata = 16'd5; end
            if (i == 102) cfg_we = 1'b0;
         end
         if (port == 0) begin sd_rx_valid = 1'b1; sd_rx_data = bytev(seed, i); end
         else begin usb_rx_valid = 1'b1; usb_rx_data = bytev(seed, i); end
         if (i == n - 1) chk(stat_busy == 1'b1, "R4 busy before final byte", stat_busy, 1);
         do begin
            #1;
            got = (port == 0) ? sd_rx_ready : usb_rx_ready;
            @(negedge clk);
         end while (!got);
      end
      sd_rx_valid = 1'b0; usb_rx_valid = 1'b0;
   endtask

   task automatic pull(input int port, input int n);
      int i = 0;
      int cyc = 0;
      logic v;
      while (i < n) begin
         if (port == 0) sd_tx_ready = (cyc % 3 != 2);
         else usb_tx_ready = (cyc % 3 != 2);
         #1;
         v = (port == 0) ? (sd_tx_valid && sd_tx_ready) : (usb_tx_valid && usb_tx_ready);
         if (v) begin
            rx_bytes[i] = (port == 0) ? sd_tx_data : usb_tx_data;
            i++;
         end
         cyc++;
         @(negedge clk);
      end
      sd_tx_ready = 1'b0; usb_tx_ready = 1'b0;
   endtask

   task automatic t_reset();
      chk(stat_busy == 1'b0, "R1 busy", stat_busy, 0);
      chk(stat_timeout == 1'b0, "R1 timeout", stat_timeout, 0);
      chk({sd_rx_ready, usb_rx_ready, sd_tx_valid, usb_tx_valid} == 4'b0, "R1 streams",
          {sd_rx_ready, usb_rx_ready, sd_tx_valid, usb_tx_valid}, 0);
      chk({mem_wr, mem_rd} == 2'b0, "R1 mem strobes", {mem_wr, mem_rd}, 0);
   endtask

   task automatic t_sd_in();
      int v0 = viol;
      int w0;
      int bad = 0;
      exp_code = 1;
      cfg_wr(2'd0, 16'd1);
      cfg_wr(2'd1, 16'd1);
      w0 = wr_cnt;
      cfg_wr(2'd2, 16'd1);
      chk(stat_busy == 1'b1, "R2 busy after code 1", stat_busy, 1);
      push(0, 1024, 7, 1'b1);
      chk(stat_busy == 1'b0, "R4 busy falls on final byte", stat_busy, 0);
      @(negedge clk);
      chk(wr_cnt - w0 == 512, "R4 R11 word count for L=1", wr_cnt - w0, 512);
      for (int k = 0; k < 512; k++) begin
         logic [15:0] e = {bytev(7, 2 * k), bytev(7, 2 * k + 1)};
         if (wmem[12'h400 + k] !== e) begin
            bad++;
            chk(1'b0, "R5 R6 inbound word", wmem[12'h400 + k], e);
         end
      end
      chk(bad == 0, "R6 big-endian packing at base 0x800", bad, 0);
      chk(viol == v0, "R8 R11 no stray stream handshake", viol - v0, 0);
      exp_code = 0;
   endtask

   task automatic t_out(input int port, input int code, input int base);
      int v0 = viol;
      int w0;
      int bad = 0;
      exp_code = code;
      cfg_wr(2'd0, 16'd0);
      cfg_wr(2'd1, 16'(base));
      w0 = wr_cnt;
      cfg_wr(2'd2, 16'(code));
      chk(stat_busy == 1'b1, "R2 busy after outbound code", stat_busy, 1);
      pull(port, 512);
      chk(stat_busy == 1'b0, "R4 outbound ends after 512 bytes", stat_busy, 0);
      for (int j = 0; j < 512; j++) begin
         logic [15:0] w = rdpat(12'(base * 1024 + j / 2));
         logic [7:0] e = (j % 2 == 0) ? w[15:8] : w[7:0];
         if (rx_bytes[j] !== e) begin
            bad++;
            chk(1'b0, "R7 R5 outbound byte", rx_bytes[j], e);
         end
      end
      chk(bad == 0, "R7 high byte first", bad, 0);
      chk(wr_cnt == w0, "R7 no writes outbound", wr_cnt - w0, 0);
      chk(viol == v0, "R8 only selected stream", viol - v0, 0);
      exp_code = 0;
   endtask

   task automatic t_timeout();
      int w0;
      exp_code = 1;
      cfg_wr(2'd0, 16'd0);
      cfg_wr(2'd1, 16'd3);
      w0 = wr_cnt;
      cfg_wr(2'd2, 16'd1);
      push(0, 9, 11, 1'b0);
      repeat (4095) @(negedge clk);
      chk(stat_busy == 1'b1, "R9 busy one cycle before limit", stat_busy, 1);
      @(negedge clk);
      chk(stat_busy == 1'b0, "R9 busy drops at limit", stat_busy, 0);
      chk(stat_timeout == 1'b1, "R9 timeout set", stat_timeout, 1);
      chk(sd_rx_ready == 1'b0, "R9 stream released", sd_rx_ready, 0);
      @(negedge clk);
      chk(wr_cnt - w0 == 4, "R9 odd byte discarded", wr_cnt - w0, 4);
      chk(wmem[12'hC03] === {bytev(11, 6), bytev(11, 7)}, "R9 last full word",
          wmem[12'hC03], {bytev(11, 6), bytev(11, 7)});
      exp_code = 0;
   endtask

   task automatic t_bad_cmd();
      logic [15:0] codes [4] = '{16'd0, 16'd5, 16'd7, 16'hFFFF};
      for (int c = 0; c < 4; c++) begin
         cfg_wr(2'd2, codes[c]);
         chk(stat_busy == 1'b0, "R3 bad code leaves idle", stat_busy, 0);
         chk(stat_timeout == 1'b1, "R3 R10 flag kept", stat_timeout, 1);
      end
      repeat (3) @(negedge clk);
      chk(stat_timeout == 1'b1, "R10 sticky while idle", stat_timeout, 1);
   endtask

   task automatic t_clear();
      int w0;
      int bad = 0;
      exp_code = 3;
      cfg_wr(2'd0, 16'd0);
      cfg_wr(2'd1, 16'd0);
      w0 = wr_cnt;
      cfg_wr(2'd2, 16'd3);
      chk(stat_busy == 1'b1, "R2 busy after code 3", stat_busy, 1);
      chk(stat_timeout == 1'b0, "R10 cleared by new command", stat_timeout, 0);
      push(1, 512, 13, 1'b0);
      @(negedge clk);
      chk(wr_cnt - w0 == 256, "R4 L=0 moves 512 bytes", wr_cnt - w0, 256);
      for (int k = 0; k < 256; k++)
         if (wmem[k] !== {bytev(13, 2 * k), bytev(13, 2 * k + 1)}) bad++;
      chk(bad == 0, "R6 USB inbound words at base 0", bad, 0);
      chk(stat_timeout == 1'b0, "R10 clean run no timeout", stat_timeout, 0);
      exp_code = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R4 act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 16'd0;
      sd_rx_valid = 1'b0; sd_rx_data = 8'd0; sd_tx_ready = 1'b0;
      usb_rx_valid = 1'b0; usb_rx_data = 8'd0; usb_tx_ready = 1'b0;
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sd_in();
      t_out(1, 4, 2);
      t_out(0, 2, 3);
      t_timeout();
      t_bad_cmd();
      t_clear();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule